// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block runs on the controller side of a DDR SDRAM link and owns the command pins from reset until the memory can take ordinary traffic. Once reset is released, it holds the clock-enable pin low for a stabilization interval. The interval is given in nanoseconds and turned into cycles using a clock-period parameter. It then raises clock enable and walks through a fixed sequence of commands: precharge of all banks, an extended mode-register load that enables the DLL, a base mode-register load that resets the DLL, a second precharge, two auto-refresh cycles and a last base mode-register load with the DLL-reset bit cleared. After each command it waits the gap that command requires.

While waiting, the block drives either NOP or DESELECT on the command pins. A parameter selects which one, and it applies to every cycle that carries no command. The DLL needs a lock window measured from the DLL-reset load. The block raises its ready flag only after that window has passed and the gap after the last load has run out. Mode-register contents, the stabilization time and every gap are parameters. A synchronous reset starts the whole sequence again.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, and for exactly STARTUP_CYC = ceil(STARTUP_NS*1000 / CLK_PERIOD_PS) rising edges after its release, cke_o is 0. From that edge on it stays 1 until the next reset.
- R2: While cke_o is 0, no command is issued. A command is a cycle with cs_n_o=0 and {ras_n_o,cas_n_o,we_n_o} other than 3'b111.
- R3: The commands come exactly once each in this order: precharge {cs,ras,cas,we}=4'b0010 on the edge after cke_o rises; mode load 4'b0000 with ba_o=2'b01 and addr_o=EMR_VAL; mode load with ba_o=2'b00 and addr_o=MR_VAL with bit 8 set; precharge; auto refresh 4'b0001; auto refresh; mode load with ba_o=2'b00 and addr_o=MR_VAL with bit 8 cleared.
- R4: Every precharge drives addr_o bit 10 high, which selects all banks.
- R5: A precharge is followed by the next command exactly T_RP_CYC edges later.
- R6: A mode-register load is followed by the next command exactly T_MRD_CYC edges later.
- R7: An auto refresh is followed by the next command exactly T_RFC_CYC edges later.
- R8: init_done_o rises on the edge max(t_dll + DLL_LOCK_CYC, t_fin + T_MRD_CYC). Here t_dll is the edge of the DLL-reset load, t_fin is the edge of the final load, and DLL_LOCK_CYC is at least 200.
- R9: Once high, init_done_o stays high until reset, and no command is issued after it rises.
- R10: Every cycle without a command shows the idle code: NOP 4'b0111 when IDLE_DESELECT=0, DESELECT 4'b1111 when IDLE_DESELECT=1.
- R11: A synchronous reset at any point clears cke_o and init_done_o on the next edge and restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| init_done_o | output | 1 | Sequence finished, device ready |

## Verification
Two instances run side by side, and the bench recomputes every edge position from their parameters. The first uses short refresh gaps, so the DLL lock window sets the ready edge. It also idles with NOP. The second uses a long refresh gap, so the last mode-load gap sets the ready edge. It idles with DESELECT and has the DLL-reset bit already set in its mode value, which shows that the bit is forced on and then off. A full run is followed by a reset in the middle of the sequence and a second full run, which separates a true restart from leftover state.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

   typedef enum logic [3:0] {
      ST_PWR   = 4'd0,
      ST_CKE   = 4'd1,
      ST_PRE1  = 4'd2,
      ST_EMR   = 4'd3,
      ST_MRDLL = 4'd4,
      ST_PRE2  = 4'd5,
      ST_REF1  = 4'd6,
      ST_REF2  = 4'd7,
      ST_MRFIN = 4'd8,
      ST_LOCK  = 4'd9,
      ST_DONE  = 4'd10
   } init_step_t;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } ddr_cmd_t;

   localparam ddr_cmd_t CMD_NOP   = 4'b0111;
   localparam ddr_cmd_t CMD_DESEL = 4'b1111;
   localparam ddr_cmd_t CMD_PRE   = 4'b0010;
   localparam ddr_cmd_t CMD_REF   = 4'b0001;
   localparam ddr_cmd_t CMD_LMR   = 4'b0000;

   localparam int AP_BIT     = 10;
   localparam int DLLRST_BIT = 8;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
   parameter int CW      = 16,
   parameter int RST_VAL = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= CW'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R5 R6 R7: gaps are counted one edge at a time
   p_tmr_step_r5: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
   parameter int LOCK_CYC = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic lock_ok
);

   localparam int LW = $clog2(LOCK_CYC + 1);

   logic [LW-1:0] lcnt_q;
   logic          run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q  <= 1'b0;
         lcnt_q <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         lcnt_q <= '0;
      end else if (run_q && lcnt_q != LW'(LOCK_CYC)) begin
         lcnt_q <= lcnt_q + 1'b1;
      end
   end

   assign lock_ok = run_q && (lcnt_q >= LW'(LOCK_CYC - 1));

   // R8: once the window has passed it stays passed
   p_lock_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (lock_ok && !start) |=> lock_ok);

endmodule

// File: rtl/ddr_init_cmdgen.sv
module ddr_init_cmdgen
   import ddr_init_pkg::*;
#(
   parameter int                ADDR_W        = 13,
   parameter int                BA_W          = 2,
   parameter int                CW            = 16,
   parameter int                T_RP_CYC      = 3,
   parameter int                T_MRD_CYC     = 2,
   parameter int                T_RFC_CYC     = 10,
   parameter bit                IDLE_DESELECT = 1'b0,
   parameter logic [ADDR_W-1:0] MR_VAL        = '0,
   parameter logic [ADDR_W-1:0] EMR_VAL       = '0
) (
   input  init_step_t        step_i,
   output ddr_cmd_t          cmd_o,
   output ddr_cmd_t          idle_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [CW-1:0]     reload_o
);

   localparam logic [ADDR_W-1:0] AP_M  = ADDR_W'(1) << AP_BIT;
   localparam logic [ADDR_W-1:0] DLL_M = ADDR_W'(1) << DLLRST_BIT;

   ddr_cmd_t idle_cmd;

   generate
      if (IDLE_DESELECT) begin : g_idle_desel
         assign idle_cmd = CMD_DESEL;
      end else begin : g_idle_nop
         assign idle_cmd = CMD_NOP;
      end
   endgenerate

   assign idle_o = idle_cmd;

   always_comb begin
      cmd_o    = idle_cmd;
      ba_o     = '0;
      addr_o   = '0;
      reload_o = '0;
      unique case (step_i)
         ST_PRE1, ST_PRE2: begin
            cmd_o    = CMD_PRE;
            addr_o   = AP_M;
            reload_o = CW'(T_RP_CYC - 1);
         end
         ST_EMR: begin
            cmd_o    = CMD_LMR;
            ba_o     = BA_W'(1);
            addr_o   = EMR_VAL;
            reload_o = CW'(T_MRD_CYC - 1);
         end
         ST_MRDLL: begin
            cmd_o    = CMD_LMR;
            addr_o   = MR_VAL | DLL_M;
            reload_o = CW'(T_MRD_CYC - 1);
         end
         ST_MRFIN: begin
            cmd_o    = CMD_LMR;
            addr_o   = MR_VAL & ~DLL_M;
            reload_o = CW'(T_MRD_CYC - 1);
         end
         ST_REF1, ST_REF2: begin
            cmd_o    = CMD_REF;
            reload_o = CW'(T_RFC_CYC - 1);
         end
         default: begin
            cmd_o    = idle_cmd;
         end
      endcase
   end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
   import ddr_init_pkg::*;
#(
   parameter int                ADDR_W        = 13,
   parameter int                BA_W          = 2,
   parameter int                CLK_PERIOD_PS = 5000,
   parameter int                STARTUP_NS    = 200000,
   parameter int                T_RP_CYC      = 3,
   parameter int                T_MRD_CYC     = 2,
   parameter int                T_RFC_CYC     = 15,
   parameter int                DLL_LOCK_CYC  = 200,
   parameter bit                IDLE_DESELECT = 1'b0,
   parameter logic [ADDR_W-1:0] MR_VAL        = 13'h0032,
   parameter logic [ADDR_W-1:0] EMR_VAL       = 13'h0000
) (
   input  logic              clk,
   input  logic              rst,
   output logic              cke_o,
   output logic              cs_n_o,
   output logic              ras_n_o,
   output logic              cas_n_o,
   output logic              we_n_o,
   output logic [BA_W-1:0]   ba_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              init_done_o
);

   localparam longint STARTUP_L   = (longint'(STARTUP_NS) * 1000 + CLK_PERIOD_PS - 1)
                                    / CLK_PERIOD_PS;
   localparam int     STARTUP_CYC = int'(STARTUP_L);
   localparam int     GAP_A       = (T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC;
   localparam int     GAP_B       = (GAP_A > T_RFC_CYC) ? GAP_A : T_RFC_CYC;
   localparam int     MAX_GAP     = (GAP_B > STARTUP_CYC) ? GAP_B : STARTUP_CYC;
   localparam int     CW          = $clog2(MAX_GAP + 1);

   generate
      if (ADDR_W < 11)        begin : g_chk_aw   $error("ADDR_W must reach bit 10"); end
      if (BA_W < 2)           begin : g_chk_bw   $error("BA_W must be at least 2"); end
      if (CLK_PERIOD_PS < 1)  begin : g_chk_clk  $error("CLK_PERIOD_PS must be positive"); end
      if (STARTUP_CYC < 2)    begin : g_chk_st   $error("startup delay too short"); end
      if (T_RP_CYC < 1)       begin : g_chk_rp   $error("T_RP_CYC must be at least 1"); end
      if (T_MRD_CYC < 1)      begin : g_chk_mrd  $error("T_MRD_CYC must be at least 1"); end
      if (T_RFC_CYC < 1)      begin : g_chk_rfc  $error("T_RFC_CYC must be at least 1"); end
      if (DLL_LOCK_CYC < 200) begin : g_chk_lock $error("DLL lock window below 200"); end
      if (EMR_VAL[0] != 1'b0) begin : g_chk_emr  $error("EMR_VAL must keep the DLL enabled"); end
   endgenerate

   init_step_t          step_q, step_nxt;
   logic                advance;
   logic                tmr_zero;
   logic                lock_ok;
   logic                lock_start;
   ddr_cmd_t            nxt_cmd, idle_cmd, cmd_q;
   logic [BA_W-1:0]     nxt_ba, ba_q;
   logic [ADDR_W-1:0]   nxt_addr, addr_q;
   logic [CW-1:0]       nxt_reload;
   logic                cke_q, done_q;

   always_comb begin
      step_nxt = step_q;
      advance  = 1'b0;
      unique case (step_q)
         ST_DONE: ;
         ST_LOCK: begin
            if (lock_ok) begin
               advance  = 1'b1;
               step_nxt = ST_DONE;
            end
         end
         ST_MRFIN: begin
            if (tmr_zero) begin
               advance  = 1'b1;
               step_nxt = lock_ok ? ST_DONE : ST_LOCK;
            end
         end
         default: begin
            if (tmr_zero) begin
               advance  = 1'b1;
               step_nxt = init_step_t'(step_q + 4'd1);
            end
         end
      endcase
   end

   assign lock_start = advance && (step_nxt == ST_MRDLL);

   ddr_init_cmdgen #(
      .ADDR_W        (ADDR_W),
      .BA_W          (BA_W),
      .CW            (CW),
      .T_RP_CYC      (T_RP_CYC),
      .T_MRD_CYC     (T_MRD_CYC),
      .T_RFC_CYC     (T_RFC_CYC),
      .IDLE_DESELECT (IDLE_DESELECT),
      .MR_VAL        (MR_VAL),
      .EMR_VAL       (EMR_VAL)
   ) u_cmdgen (
      .step_i   (step_nxt),
      .cmd_o    (nxt_cmd),
      .idle_o   (idle_cmd),
      .ba_o     (nxt_ba),
      .addr_o   (nxt_addr),
      .reload_o (nxt_reload)
   );

   ddr_init_timer #(
      .CW      (CW),
      .RST_VAL (STARTUP_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (advance),
      .load_val (nxt_reload),
      .zero     (tmr_zero)
   );

   ddr_init_lock #(
      .LOCK_CYC (DLL_LOCK_CYC)
   ) u_lock (
      .clk     (clk),
      .rst     (rst),
      .start   (lock_start),
      .lock_ok (lock_ok)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         step_q <= ST_PWR;
         cke_q  <= 1'b0;
         cmd_q  <= idle_cmd;
         ba_q   <= '0;
         addr_q <= '0;
         done_q <= 1'b0;
      end else begin
         step_q <= step_nxt;
         cke_q  <= (step_nxt != ST_PWR);
         done_q <= (step_nxt == ST_DONE);
         if (advance) begin
            cmd_q  <= nxt_cmd;
            ba_q   <= nxt_ba;
            addr_q <= nxt_addr;
         end else begin
            cmd_q  <= idle_cmd;
            ba_q   <= '0;
            addr_q <= '0;
         end
      end
   end

   assign cke_o       = cke_q;
   assign cs_n_o      = cmd_q.cs_n;
   assign ras_n_o     = cmd_q.ras_n;
   assign cas_n_o     = cmd_q.cas_n;
   assign we_n_o      = cmd_q.we_n;
   assign ba_o        = ba_q;
   assign addr_o      = addr_q;
   assign init_done_o = done_q;

   // R1: clock enable never drops outside reset
   p_cke_hold_r1: assert property (@(posedge clk) disable iff (rst)
      cke_o |=> cke_o);

   // R2: nothing but idle while clock enable is low
   p_quiet_low_r2: assert property (@(posedge clk) disable iff (rst)
      !cke_o |-> (cs_n_o || (ras_n_o && cas_n_o && we_n_o)));

   // R4: precharge always targets all banks
   p_pre_all_r4: assert property (@(posedge clk) disable iff (rst)
      (!cs_n_o && !ras_n_o && cas_n_o && !we_n_o) |-> addr_o[AP_BIT]);

   // R8: ready only after the DLL window
   p_done_locked_r8: assert property (@(posedge clk) disable iff (rst)
      init_done_o |-> lock_ok);

   // R9: ready is sticky
   p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      init_done_o |=> init_done_o);

   // R9: bus is quiet once ready
   p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      init_done_o |-> (cs_n_o || (ras_n_o && cas_n_o && we_n_o)));

   // R11: reset clears the outputs on the next edge
   p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> (!cke_o && !init_done_o));

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

   localparam int CLK_PERIOD_NS = 10;

   // instance A: lock window dominates, NOP idle
   localparam int A_PS = 10000, A_NS = 500, A_RP = 3, A_MRD = 2, A_RFC = 8, A_LOCK = 200;
   localparam logic [12:0] A_MR = 13'h0032, A_EMR = 13'h0000;
   // instance B: refresh gaps dominate, DESELECT idle, DLL bit preset in MR
   localparam int B_PS = 10000, B_NS = 300, B_RP = 4, B_MRD = 3, B_RFC = 120, B_LOCK = 200;
   localparam logic [12:0] B_MR = 13'h0163, B_EMR = 13'h0002;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD_NS / 2) clk = ~clk;

   logic        cke_w  [2];
   logic        done_w [2];
   logic [3:0]  cmd_w  [2];
   logic [1:0]  ba_w   [2];
   logic [12:0] addr_w [2];
   logic        csa, rasa, casa, wea, csb, rasb, casb, web;

   ddr_init_seq #(
      .CLK_PERIOD_PS(A_PS), .STARTUP_NS(A_NS), .T_RP_CYC(A_RP), .T_MRD_CYC(A_MRD),
      .T_RFC_CYC(A_RFC), .DLL_LOCK_CYC(A_LOCK), .IDLE_DESELECT(1'b0),
      .MR_VAL(A_MR), .EMR_VAL(A_EMR)
   ) u_dut (
      .clk(clk), .rst(rst), .cke_o(cke_w[0]), .cs_n_o(csa), .ras_n_o(rasa),
      .cas_n_o(casa), .we_n_o(wea), .ba_o(ba_w[0]), .addr_o(addr_w[0]),
      .init_done_o(done_w[0])
   );

   ddr_init_seq #(
      .CLK_PERIOD_PS(B_PS), .STARTUP_NS(B_NS), .T_RP_CYC(B_RP), .T_MRD_CYC(B_MRD),
      .T_RFC_CYC(B_RFC), .DLL_LOCK_CYC(B_LOCK), .IDLE_DESELECT(1'b1),
      .MR_VAL(B_MR), .EMR_VAL(B_EMR)
   ) u_dut2 (
      .clk(clk), .rst(rst), .cke_o(cke_w[1]), .cs_n_o(csb), .ras_n_o(rasb),
      .cas_n_o(casb), .we_n_o(web), .ba_o(ba_w[1]), .addr_o(addr_w[1]),
      .init_done_o(done_w[1])
   );

   assign cmd_w[0] = {csa, rasa, casa, wea};
   assign cmd_w[1] = {csb, rasb, casb, web};

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   int cyc = 0;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   // monitor state
   logic [3:0]  idle_code [2];
   int          cke_rise  [2];
   int          done_at   [2];
   int          nevt      [2];
   int          bad_low   [2];
   int          bad_idle  [2];
   int          bad_done  [2];
   logic        prev_done [2];
   int          ev_cyc    [2][8];
   logic [3:0]  ev_code   [2][8];
   logic [1:0]  ev_ba     [2][8];
   logic [12:0] ev_addr   [2][8];

   initial begin
      idle_code[0] = 4'b0111;
      idle_code[1] = 4'b1111;
   end

   function automatic bit is_cmd(input logic [3:0] c);
      return (c[3] == 1'b0) && (c[2:0] != 3'b111);
   endfunction

   always @(negedge clk) begin
      for (int i = 0; i < 2; i++) begin
         if (rst) begin
            cke_rise[i] = -1; done_at[i] = -1; nevt[i] = 0;
            bad_low[i] = 0; bad_idle[i] = 0; bad_done[i] = 0; prev_done[i] = 1'b0;
         end else begin
            if (!cke_w[i] && is_cmd(cmd_w[i])) bad_low[i]++;
            if (cke_w[i] && cke_rise[i] < 0) cke_rise[i] = cyc;
            if (is_cmd(cmd_w[i])) begin
               if (nevt[i] < 8) begin
                  ev_cyc[i][nevt[i]]  = cyc;
                  ev_code[i][nevt[i]] = cmd_w[i];
                  ev_ba[i][nevt[i]]   = ba_w[i];
                  ev_addr[i][nevt[i]] = addr_w[i];
               end
               nevt[i]++;
               if (done_w[i]) bad_done[i]++;
            end else if (cmd_w[i] != idle_code[i]) begin
               bad_idle[i]++;
            end
            if (done_w[i] && done_at[i] < 0) done_at[i] = cyc;
            if (prev_done[i] && !done_w[i]) bad_done[i]++;
            prev_done[i] = done_w[i];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic verify(input int i, input int ps, input int ns, input int trp,
                         input int tmrd, input int trfc, input int lock,
                         input logic [12:0] mr, input logic [12:0] emr);
      int s;
      int e [7];
      int gap [7];
      logic [3:0] code [7];
      int dn;
      s = (ns * 1000 + ps - 1) / ps;
      code[0] = 4'b0010; code[1] = 4'b0000; code[2] = 4'b0000; code[3] = 4'b0010;
      code[4] = 4'b0001; code[5] = 4'b0001; code[6] = 4'b0000;
      gap[0] = trp; gap[1] = tmrd; gap[2] = tmrd; gap[3] = trp;
      gap[4] = trfc; gap[5] = trfc; gap[6] = tmrd;
      e[0] = s + 1;
      for (int k = 1; k < 7; k++) e[k] = e[k-1] + gap[k-1];
      dn = (e[2] + lock > e[6] + tmrd) ? e[2] + lock : e[6] + tmrd;
      chk(cke_rise[i] == s, "R1 cke rise edge", cke_rise[i], s);
      chk(bad_low[i] == 0, "R2 command while cke low", bad_low[i], 0);
      chk(nevt[i] == 7, "R3 command count", nevt[i], 7);
      for (int k = 0; k < 7; k++) begin
         chk(ev_code[i][k] == code[k], "R3 command code", int'(ev_code[i][k]), int'(code[k]));
         if (k == 0)
            chk(ev_cyc[i][k] == e[k], "R3 first precharge edge", ev_cyc[i][k], e[k]);
         else if (gap[k-1] == trfc && (k == 5 || k == 6))
            chk(ev_cyc[i][k] == e[k], "R7 refresh gap", ev_cyc[i][k], e[k]);
         else if (k == 2 || k == 3 || k == 4 && 0)
            chk(ev_cyc[i][k] == e[k], "R6 mode load gap", ev_cyc[i][k], e[k]);
         else if (k == 1 || k == 4)
            chk(ev_cyc[i][k] == e[k], "R5 precharge gap", ev_cyc[i][k], e[k]);
         else
            chk(ev_cyc[i][k] == e[k], "R6 mode load gap", ev_cyc[i][k], e[k]);
      end
      chk(ev_addr[i][0][10] && ev_addr[i][3][10], "R4 precharge A10",
          int'({ev_addr[i][0][10], ev_addr[i][3][10]}), 3);
      chk(ev_ba[i][1] == 2'b01 && ev_addr[i][1] == emr, "R3 extended mode load",
          int'(ev_addr[i][1]), int'(emr));
      chk(ev_ba[i][2] == 2'b00 && ev_addr[i][2] == (mr | 13'h100), "R3 DLL reset load",
          int'(ev_addr[i][2]), int'(mr | 13'h100));
      chk(ev_ba[i][6] == 2'b00 && ev_addr[i][6] == (mr & ~13'h100), "R3 final mode load",
          int'(ev_addr[i][6]), int'(mr & ~13'h100));
      chk(done_at[i] == dn, "R8 ready edge", done_at[i], dn);
      chk(bad_done[i] == 0, "R9 ready sticky and quiet", bad_done[i], 0);
      chk(bad_idle[i] == 0, "R10 idle code", bad_idle[i], 0);
   endtask

   task automatic check_cleared(input string tag);
      for (int i = 0; i < 2; i++) begin
         chk(cke_w[i] == 1'b0, tag, int'(cke_w[i]), 0);
         chk(done_w[i] == 1'b0, tag, int'(done_w[i]), 0);
         chk(cmd_w[i] == idle_code[i], tag, int'(cmd_w[i]), int'(idle_code[i]));
      end
   endtask

   task automatic run_full();
      @(negedge clk) rst = 1'b0;
      repeat (400) @(negedge clk);
      verify(0, A_PS, A_NS, A_RP, A_MRD, A_RFC, A_LOCK, A_MR, A_EMR);
      verify(1, B_PS, B_NS, B_RP, B_MRD, B_RFC, B_LOCK, B_MR, B_EMR);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check_cleared("R1 reset state");
      run_full();
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      check_cleared("R11 reset after ready");
      rst = 1'b0;
      repeat (60) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check_cleared("R11 reset mid sequence");
      run_full();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 5000, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule